// File: doc/BRIEF.md
# Programmable Clock Channel Divider with Synchronous Restart

This block divides a fast input clock for one output channel. The length of the high phase and the length of the low phase are each set by their own 4-bit field, so both the ratio and the duty cycle can be chosen. After any restart, a coarse phase offset lengthens the first phase, and a start-level bit picks whether the waveform begins high or low. A force bit holds the output high. A bypass bit passes the input clock straight to the output, which gives divide-by-one.

A restart request may arrive at any time and with no fixed relation to the clock. It is first retimed by a two-flop synchronizer. Its rising edge then freezes the divider at its preset state, and a counter releases the divider a fixed number of cycles later. Every channel that sees the same request therefore restarts on the same clock edge. A channel can opt out, and then it keeps running without a break.

Top module: `clkdiv_chan`

## Requirements
- R1: While `rst_i` is high, `clk_o` sits at the level chosen by `start_high_i`. After the last reset edge, the first transition comes after the first phase length has elapsed. The first phase length is (selected field + 1 + `phase_ofs_i`) input cycles, and the selected field is `high_cyc_i` when `start_high_i`=1, else `low_cyc_i`.
- R2: While running, each high phase lasts `high_cyc_i`+1 input cycles and each low phase lasts `low_cyc_i`+1. The ratio therefore spans 2 to 32. A change of either field takes effect when the next phase of that level is loaded.
- R3: `phase_ofs_i` adds its value in cycles to the first phase after a reset or a sync release, and to no later phase.
- R4: `start_high_i`=1 makes the waveform start high with the high count. `start_high_i`=0 makes it start low with the low count.
- R5: With `bypass_i`=1, `clk_o` equals the input clock (divide-by-one), except while a sync hold is active. During the hold it stays at the start level.
- R6: With `force_high_i`=1, `clk_o` is 1 whatever the other inputs are.
- R7: Let edge E be the first clock edge that samples `sync_req_i` high after a low sample. From edge E+2 through edge E+SYNC_LAT (default 14), the divider is held at its preset state and the output is static. From the next edge on, it runs from that preset. Only a low-to-high change of the request triggers this; keeping the request high does not trigger it again.
- R8: With `nosync_i`=1, a sync request has no effect on the channel. It keeps dividing without interruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_req_i | input | 1 | Asynchronous restart request, acts on its rising edge |
| low_cyc_i | input | 4 | Low phase length minus one |
| high_cyc_i | input | 4 | High phase length minus one |
| phase_ofs_i | input | 4 | Extra cycles added to the first phase after a restart |
| start_high_i | input | 1 | Level (and count) the waveform starts with |
| force_high_i | input | 1 | Holds the output at 1 |
| bypass_i | input | 1 | Passes the input clock straight through |
| nosync_i | input | 1 | Excludes this channel from sync restarts |
| clk_o | output | 1 | Divided clock output |

## Verification
The embedded properties assume that `sync_req_i` changes away from clock edges, and that each high or low level lasts at least two cycles, so that the edge detector sees every transition. They also assume configuration inputs that are sampled clean at the clock. The stimulus changes configuration only at falling edges. It moves the request half a nanosecond after a falling edge, keeps every request pulse and every gap several cycles wide, and spaces restarts further apart than the release latency, except for one deliberately long request used to show that a held level does not trigger again.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int FIELD_W = 4;
    localparam int CNT_W   = FIELD_W + 1;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef struct packed {
        field_t low_cyc;
        field_t high_cyc;
        field_t phase;
        logic   start_high;
    } chan_cfg_t;

    // Counter value loaded at restart: first phase minus one, plus offset
    function automatic cnt_t preset_count(input chan_cfg_t c);
        cnt_t base;
        base = c.start_high ? cnt_t'(c.high_cyc) : cnt_t'(c.low_cyc);
        return base + cnt_t'(c.phase);
    endfunction

endpackage

// File: rtl/clkdiv_sync_edge.sv
module clkdiv_sync_edge (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    output logic rise_o
);
    logic meta_q, stab_q, prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= req_i;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign rise_o = stab_q & ~prev_q;

    // R7
    rise_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_o |=> !rise_o);

endmodule

// File: rtl/clkdiv_release.sv
module clkdiv_release #(
    parameter int SYNC_LAT = 14
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    output logic hold_o
);
    localparam int RC_W = (SYNC_LAT > 4) ? $clog2(SYNC_LAT) : 2;
    localparam logic [RC_W-1:0] RC_INIT = RC_W'(SYNC_LAT - 3);

    logic [RC_W-1:0] rc_q;
    logic            hold_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= 1'b0;
            rc_q   <= '0;
        end else if (start_i) begin
            hold_q <= 1'b1;
            rc_q   <= RC_INIT;
        end else if (hold_q) begin
            if (rc_q == '0) hold_q <= 1'b0;
            else            rc_q   <= rc_q - 1'b1;
        end
    end

    assign hold_o = hold_q;

    // R7
    hold_keep_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold_q && rc_q != '0) |=> hold_q);

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      load_i,
    input  chan_cfg_t cfg_i,
    output logic      lvl_o
);
    cnt_t cnt_q;
    logic lvl_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || load_i) begin
            lvl_q <= cfg_i.start_high;
            cnt_q <= preset_count(cfg_i);
        end else if (cnt_q == '0) begin
            lvl_q <= ~lvl_q;
            cnt_q <= lvl_q ? cnt_t'(cfg_i.low_cyc) : cnt_t'(cfg_i.high_cyc);
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign lvl_o = lvl_q;

    // R2
    toggle_on_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_q != $past(lvl_q)) |-> ($past(cnt_q) == '0 || $past(load_i) || $past(rst_i)));

    // R4
    preset_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> (lvl_q == $past(cfg_i.start_high)));

endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int SYNC_LAT = 14
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               sync_req_i,
    input  logic [FIELD_W-1:0] low_cyc_i,
    input  logic [FIELD_W-1:0] high_cyc_i,
    input  logic [FIELD_W-1:0] phase_ofs_i,
    input  logic               start_high_i,
    input  logic               force_high_i,
    input  logic               bypass_i,
    input  logic               nosync_i,
    output logic               clk_o
);
    chan_cfg_t cfg;
    logic      rise, start, hold, load, lvl;

    always_comb begin
        cfg.low_cyc    = low_cyc_i;
        cfg.high_cyc   = high_cyc_i;
        cfg.phase      = phase_ofs_i;
        cfg.start_high = start_high_i;
    end

    clkdiv_sync_edge u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (sync_req_i),
        .rise_o (rise)
    );

    assign start = rise & ~nosync_i;

    clkdiv_release #(.SYNC_LAT(SYNC_LAT)) u_rel (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (start),
        .hold_o  (hold)
    );

    assign load = start | hold;

    clkdiv_core u_core (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (load),
        .cfg_i  (cfg),
        .lvl_o  (lvl)
    );

    always_comb begin
        if (force_high_i)          clk_o = 1'b1;
        else if (bypass_i && !hold) clk_o = clk_i;
        else                        clk_o = lvl;
    end

    // R8
    nosync_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(hold) |-> !$past(nosync_i));

    // R7
    hold_static_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (hold && $past(hold) && $stable(start_high_i)) |-> $stable(lvl));

endmodule

// File: tb/clkdiv_chan_tb_top.sv
`timescale 1ns/1ps
module clkdiv_chan_tb_top;
    localparam int LAT = 14;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_req = 1'b0;
    logic [3:0] lo = 4'd2, hi = 4'd3, ph = 4'd0;
    logic st = 1'b0, frc = 1'b0, byp = 1'b0, nos = 1'b0;
    logic clk_o;

    always #2 clk = ~clk;

    clkdiv_chan #(.SYNC_LAT(LAT)) dut_i (
        .clk_i(clk), .rst_i(rst), .sync_req_i(sync_req),
        .low_cyc_i(lo), .high_cyc_i(hi), .phase_ofs_i(ph),
        .start_high_i(st), .force_high_i(frc), .bypass_i(byp),
        .nosync_i(nos), .clk_o(clk_o)
    );

    // behavioural reference
    int cyc = 0, e0 = -100, rel_end = 0, m_rem = 0;
    bit prev_s = 0, m_lvl = 0, m_hold = 0, armed = 0, done = 0;
    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    always @(posedge clk) begin
        bit ld;
        cyc++;
        armed = 1;
        ld = 0;
        if (rst) begin
            m_hold = 0; prev_s = 0; e0 = -100; ld = 1;
        end else begin
            if (cyc == e0 + 2 && !nos) begin
                ld = 1; m_hold = 1; rel_end = cyc + LAT - 2;
            end else if (m_hold) begin
                ld = 1;
                if (cyc == rel_end) m_hold = 0;
            end
            if (sync_req && !prev_s) e0 = cyc;
            prev_s = sync_req;
        end
        if (ld) begin
            m_lvl = st;
            m_rem = (st ? int'(hi) : int'(lo)) + 1 + int'(ph);
        end else begin
            m_rem--;
            if (m_rem == 0) begin
                m_lvl = ~m_lvl;
                m_rem = (m_lvl ? int'(hi) : int'(lo)) + 1;
            end
        end
    end

    task automatic compare();
        bit exp;
        exp = frc ? 1'b1 : ((byp && !m_hold) ? clk : m_lvl);
        n_cmp++;
        if (clk_o !== exp) begin
            n_bad++;
            $display("FAIL %s: t=%0t clk_o actual %b expected %b", cur_req, $time, clk_o, exp);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk); #1;
            if (armed && !done) compare();
            @(negedge clk); #1;
            if (armed && !done) compare();
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sync(input int w);
        @(negedge clk); #0.5 sync_req = 1'b1;
        repeat (w) @(negedge clk);
        #0.5 sync_req = 1'b0;
    endtask

    initial begin
        // R1: reset state and first phase after reset
        cur_req = "R1";
        run(5);
        rst = 1'b0;
        run(40);
        // R2: extreme ratios 2 and 32
        cur_req = "R2";
        lo = 4'd0; hi = 4'd0;
        run(30);
        lo = 4'd15; hi = 4'd15;
        run(100);
        lo = 4'd6; hi = 4'd1;
        run(40);
        // R3 / R4: offset and start level on a restart
        cur_req = "R3";
        ph = 4'd5; st = 1'b1; lo = 4'd3; hi = 4'd2;
        pulse_sync(4);
        run(60);
        cur_req = "R4";
        st = 1'b0; ph = 4'd0;
        pulse_sync(3);
        run(50);
        // R1 again: reset mid-run with an offset
        cur_req = "R1";
        ph = 4'd3;
        @(negedge clk); rst = 1'b1;
        run(3);
        rst = 1'b0;
        run(40);
        // R7: a long request triggers exactly once
        cur_req = "R7";
        ph = 4'd1; st = 1'b1;
        pulse_sync(40);
        run(50);
        pulse_sync(2);
        run(40);
        // R8: opt-out keeps the channel running
        cur_req = "R8";
        nos = 1'b1;
        pulse_sync(4);
        run(50);
        nos = 1'b0;
        run(10);
        // R5: bypass, including a hold inside it
        cur_req = "R5";
        byp = 1'b1; st = 1'b0;
        run(20);
        pulse_sync(3);
        run(40);
        byp = 1'b0;
        run(10);
        // R6: force high overrides everything
        cur_req = "R6";
        frc = 1'b1;
        run(10);
        pulse_sync(3);
        byp = 1'b1;
        run(30);
        frc = 1'b0; byp = 1'b0;
        run(40);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL %s: watchdog expired, actual running expected finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule